// File: doc/BRIEF.md
# Receive Offset Calibration Servo Controller

This block cancels the DC offset that a receive amplifier chain adds by itself. It does this by driving a signed correction DAC. A calibration pass runs on its own once reset is released. Any later pass starts with a single-cycle request pulse from the register block.

During a pass the controller does four things:
- It drives a control that shorts the amplifier input.
- It forces every gain stage to a fixed high-gain word.
- It averages blocks of signed ADC samples.
- It walks the DAC code with a successive-approximation search until the averaged offset is small enough.

When the pass ends, the controller releases the short and the gain override, pulses a done flag, and holds the chosen code on the DAC.

Only the amplifier's own input-stage offset is seen, because the input is shorted while the block measures. Offset that comes from outside the chain is neither seen nor corrected.

Top module: `rx_offset_cal`

## Requirements
- R1: After reset is released, a pass is already in progress with no request. Busy is high and the short is asserted in the first cycle, and the pass completes on its own.
- R2: A request pulse while idle starts a new pass, and busy is high in the next cycle.
- R3: The short output is asserted for the whole pass and deasserted once it ends.
- R4: While busy, the gain output is the high-gain word 60. When idle, it follows the user gain word.
- R5: Each offset measurement is the mean of 64 consecutive valid 12-bit two's-complement samples, formed by an accumulator and an arithmetic shift right by 6. Samples with valid low do not count.
- R6: The DAC code is 8-bit two's complement, and the search runs bit by bit from bit 7 down to bit 0. The first trial is code 0. A positive mean keeps the bit under test and a zero or negative mean clears it; then the next lower bit is set for the next trial. Every trial is preceded by 16 settling cycles, so a one-measurement pass with valid samples every cycle ends 81 cycles after busy rises.
- R7: When a measured mean lies within -32..+32 inclusive, the pass ends at once and keeps the code under test.
- R8: If no trial of the 8 meets the window, the pass ends with the trial code whose mean had the smallest magnitude. The fail output is set and stays set until the next pass starts, where it clears.
- R9: A request pulse that arrives while busy has no effect. The pass ends normally with its own result, and no second pass follows.
- R10: Done is high for exactly one cycle: the cycle in which busy falls and the short and gain override are released. After that, the DAC code holds until the next pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_start_i | input | 1 | Single-cycle calibration request |
| smp_valid_i | input | 1 | ADC sample qualifier |
| smp_data_i | input | 12 | ADC sample, two's complement |
| user_gain_i | input | 6 | Gain word chosen by the user |
| gain_o | output | 6 | Gain word applied to the amplifier stages |
| force_short_o | output | 1 | Shorts the amplifier input during calibration |
| dac_code_o | output | 8 | Correction DAC code, two's complement |
| busy_o | output | 1 | Calibration pass in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Sticky flag: window not reached in the last pass |

## Verification
A plant model in the bench turns the DAC code into samples equal to a raw offset minus twice the signed code. The bench runs passes with raw offsets of 0, +32, +33, -33, 200, +1500 and -1500:
- 0 and +32 end after the first trial, which shows that the window edge is inclusive.
- +33 and -33 step the search in opposite directions and land on +32 and -32.
- 200 needs three trials.
- ±1500 cannot be reached, so they test how the block keeps its best code and sets fail.

The same cases are repeated with two other sample streams. One has valid high only every third cycle and a large value in the invalid slots, which shows whether unqualified samples are dropped. The other alternates ±100 around the offset, which separates a true 64-sample mean from a single-sample reading. One pass also receives a second request while it runs, to show that the request is ignored.

// File: rtl/rxcal_pkg.sv
package rxcal_pkg;

    typedef enum logic [1:0] {
        CAL_IDLE    = 2'd0,
        CAL_SETTLE  = 2'd1,
        CAL_MEASURE = 2'd2
    } cal_state_e;

endpackage

// File: rtl/rxcal_avg.sv
// Block averager: sums 2**AVG_LOG2 qualified samples, then flags full.
module rxcal_avg #(
    parameter int SAMPLE_W = 12,
    parameter int AVG_LOG2 = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr_i,
    input  logic                       en_i,
    input  logic                       valid_i,
    input  logic signed [SAMPLE_W-1:0] sample_i,
    output logic signed [SAMPLE_W-1:0] mean_o,
    output logic                       full_o
);
    localparam int ACC_W  = SAMPLE_W + AVG_LOG2;
    localparam int CNT_W  = AVG_LOG2;
    localparam int NSAMP  = 1 << AVG_LOG2;

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic [CNT_W-1:0]        cnt;
        logic                    full;
    } avg_t;

    avg_t avg_d, avg_q;

    always_comb begin
        avg_d = avg_q;
        if (clr_i) begin
            avg_d = '0;
        end else if (en_i && valid_i && !avg_q.full) begin
            avg_d.acc = avg_q.acc + {{AVG_LOG2{sample_i[SAMPLE_W-1]}}, sample_i};
            avg_d.cnt = avg_q.cnt + 1'b1;
            if (avg_q.cnt == CNT_W'(NSAMP - 1)) begin
                avg_d.full = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            avg_q <= '0;
        end else begin
            avg_q <= avg_d;
        end
    end

    // Upper slice of the sum equals an arithmetic right shift by AVG_LOG2.
    assign mean_o = avg_q.acc[ACC_W-1:AVG_LOG2];
    assign full_o = avg_q.full;

endmodule

// File: rtl/rxcal_judge.sv
// Combinational step decision: window test, magnitude and next trial code.
module rxcal_judge #(
    parameter int SAMPLE_W = 12,
    parameter int DAC_W    = 8,
    parameter int WINDOW   = 32,
    localparam int IDX_W   = $clog2(DAC_W)
) (
    input  logic signed [SAMPLE_W-1:0] mean_i,
    input  logic [DAC_W-1:0]           trial_i,
    input  logic [IDX_W-1:0]           bit_i,
    output logic                       in_win_o,
    output logic [SAMPLE_W-1:0]        mag_o,
    output logic [DAC_W-1:0]           next_trial_o
);
    logic [DAC_W-1:0] kept;

    always_comb begin
        mag_o    = mean_i[SAMPLE_W-1] ? (~mean_i + 1'b1) : mean_i;
        in_win_o = (mag_o <= SAMPLE_W'(WINDOW));

        // Trial codes are offset binary: a higher value means more correction.
        kept = trial_i;
        if (!(mean_i > 0)) begin
            kept[bit_i] = 1'b0;
        end
        next_trial_o = kept;
        if (bit_i != '0) begin
            next_trial_o[bit_i - 1'b1] = 1'b1;
        end
    end

endmodule

// File: rtl/rx_offset_cal.sv
module rx_offset_cal
    import rxcal_pkg::*;
#(
    parameter int SAMPLE_W   = 12,
    parameter int DAC_W      = 8,
    parameter int GAIN_W     = 6,
    parameter int HIGH_GAIN  = 60,
    parameter int AVG_LOG2   = 6,
    parameter int SETTLE_CYC = 16,
    parameter int WINDOW     = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cal_start_i,
    input  logic                smp_valid_i,
    input  logic [SAMPLE_W-1:0] smp_data_i,
    input  logic [GAIN_W-1:0]   user_gain_i,
    output logic [GAIN_W-1:0]   gain_o,
    output logic                force_short_o,
    output logic [DAC_W-1:0]    dac_code_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                fail_o
);
    localparam int SET_W = $clog2(SETTLE_CYC + 1);
    localparam int IDX_W = $clog2(DAC_W);
    localparam logic [DAC_W-1:0] MID_CODE = DAC_W'(1) << (DAC_W - 1);

    typedef struct packed {
        cal_state_e          st;
        logic [SET_W-1:0]    settle;
        logic [IDX_W-1:0]    bidx;
        logic [DAC_W-1:0]    trial;
        logic [DAC_W-1:0]    best;
        logic [SAMPLE_W-1:0] best_mag;
        logic                busy;
        logic                done;
        logic                fail;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                       avg_clr, avg_en, avg_full;
    logic signed [SAMPLE_W-1:0] avg_mean;
    logic                       jd_in_win;
    logic [SAMPLE_W-1:0]        jd_mag;
    logic [DAC_W-1:0]           jd_next;
    logic                       new_best;

    assign avg_clr = (ctl_q.st != CAL_MEASURE);
    assign avg_en  = (ctl_q.st == CAL_MEASURE);

    rxcal_avg #(
        .SAMPLE_W (SAMPLE_W),
        .AVG_LOG2 (AVG_LOG2)
    ) u_avg (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (avg_clr),
        .en_i     (avg_en),
        .valid_i  (smp_valid_i),
        .sample_i (smp_data_i),
        .mean_o   (avg_mean),
        .full_o   (avg_full)
    );

    rxcal_judge #(
        .SAMPLE_W (SAMPLE_W),
        .DAC_W    (DAC_W),
        .WINDOW   (WINDOW)
    ) u_judge (
        .mean_i       (avg_mean),
        .trial_i      (ctl_q.trial),
        .bit_i        (ctl_q.bidx),
        .in_win_o     (jd_in_win),
        .mag_o        (jd_mag),
        .next_trial_o (jd_next)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        new_best   = (jd_mag < ctl_q.best_mag);
        case (ctl_q.st)
            CAL_IDLE: begin
                if (cal_start_i) begin
                    ctl_d.st       = CAL_SETTLE;
                    ctl_d.settle   = '0;
                    ctl_d.bidx     = IDX_W'(DAC_W - 1);
                    ctl_d.trial    = MID_CODE;
                    ctl_d.best     = MID_CODE;
                    ctl_d.best_mag = '1;
                    ctl_d.busy     = 1'b1;
                    ctl_d.fail     = 1'b0;
                end
            end
            CAL_SETTLE: begin
                if (ctl_q.settle == SET_W'(SETTLE_CYC - 1)) begin
                    ctl_d.st     = CAL_MEASURE;
                    ctl_d.settle = '0;
                end else begin
                    ctl_d.settle = ctl_q.settle + 1'b1;
                end
            end
            CAL_MEASURE: begin
                if (avg_full) begin
                    if (jd_in_win) begin
                        ctl_d.st   = CAL_IDLE;
                        ctl_d.busy = 1'b0;
                        ctl_d.done = 1'b1;
                    end else begin
                        if (new_best) begin
                            ctl_d.best     = ctl_q.trial;
                            ctl_d.best_mag = jd_mag;
                        end
                        if (ctl_q.bidx == '0) begin
                            ctl_d.trial = new_best ? ctl_q.trial : ctl_q.best;
                            ctl_d.st    = CAL_IDLE;
                            ctl_d.busy  = 1'b0;
                            ctl_d.done  = 1'b1;
                            ctl_d.fail  = 1'b1;
                        end else begin
                            ctl_d.trial = jd_next;
                            ctl_d.bidx  = ctl_q.bidx - 1'b1;
                            ctl_d.st    = CAL_SETTLE;
                        end
                    end
                end
            end
            default: begin
                ctl_d.st   = CAL_IDLE;
                ctl_d.busy = 1'b0;
            end
        endcase
    end

    // Reset lands directly in a pass: the power-up calibration needs no request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q          <= '0;
            ctl_q.st       <= CAL_SETTLE;
            ctl_q.bidx     <= IDX_W'(DAC_W - 1);
            ctl_q.trial    <= MID_CODE;
            ctl_q.best     <= MID_CODE;
            ctl_q.best_mag <= '1;
            ctl_q.busy     <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o        = ctl_q.busy;
    assign done_o        = ctl_q.done;
    assign fail_o        = ctl_q.fail;
    assign force_short_o = ctl_q.busy;
    assign gain_o        = ctl_q.busy ? GAIN_W'(HIGH_GAIN) : user_gain_i;
    assign dac_code_o    = {~ctl_q.trial[DAC_W-1], ctl_q.trial[DAC_W-2:0]};

endmodule

// File: rtl/rx_offset_cal_chk.sv
module rx_offset_cal_chk #(
    parameter int GAIN_W    = 6,
    parameter int DAC_W     = 8,
    parameter int HIGH_GAIN = 60
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cal_start_i,
    input logic [GAIN_W-1:0] gain_o,
    input logic              force_short_o,
    input logic [DAC_W-1:0]  dac_code_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              fail_o
);
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r10_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !force_short_o && $past(busy_o)));

    a_r4_gain_forced: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (gain_o == GAIN_W'(HIGH_GAIN)));

    a_r10_code_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !cal_start_i) |=> $stable(dac_code_o));

    a_r8_fail_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_o) |-> done_o);

    a_r2_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && cal_start_i) |=> busy_o);

endmodule

bind rx_offset_cal rx_offset_cal_chk #(
    .GAIN_W    (GAIN_W),
    .DAC_W     (DAC_W),
    .HIGH_GAIN (HIGH_GAIN)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cal_start_i   (cal_start_i),
    .gain_o        (gain_o),
    .force_short_o (force_short_o),
    .dac_code_o    (dac_code_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .fail_o        (fail_o)
);

// File: tb/rx_offset_cal_bench.sv
module rx_offset_cal_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cal_start = 1'b0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic [5:0]  user_gain = 6'd9;
    logic [5:0]  gain;
    logic        force_short, busy, done, fail;
    logic [7:0]  dac_code;

    rx_offset_cal u_rx_offset_cal (
        .clk           (clk),
        .rst_n         (rst_n),
        .cal_start_i   (cal_start),
        .smp_valid_i   (smp_valid),
        .smp_data_i    (smp_data),
        .user_gain_i   (user_gain),
        .gain_o        (gain),
        .force_short_o (force_short),
        .dac_code_o    (dac_code),
        .busy_o        (busy),
        .done_o        (done),
        .fail_o        (fail)
    );

    always #4 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int raw   = 0;
    int vmode = 0;
    int    exp_code_q[$];
    bit    exp_fail_q[$];
    string exp_req_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input int code, input bit fl, input string req);
        exp_code_q.push_back(code);
        exp_fail_q.push_back(fl);
        exp_req_q.push_back(req);
    endtask

    // Plant: the sample equals the raw offset minus twice the signed DAC code.
    initial begin
        int  ph;
        int  val;
        bit  alt;
        logic v;
        ph  = 0;
        alt = 1'b0;
        forever begin
            @(negedge clk);
            ph++;
            v = (vmode == 1) ? ((ph % 3) == 0) : 1'b1;
            if (v) begin
                val = raw - 2 * int'($signed(dac_code));
                if (vmode == 2) begin
                    val = val + (alt ? 100 : -100);
                    alt = ~alt;
                end
                if (val > 2047)  val = 2047;
                if (val < -2048) val = -2048;
                smp_data = 12'(val);
            end else begin
                smp_data = 12'h7FF;
            end
            smp_valid = v;
        end
    end

    // Monitor: compare every completion against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (exp_code_q.size() == 0) begin
                    chk(1'b0, "R10", "unexpected done", 1, 0);
                end else begin
                    int    ec;
                    bit    ef;
                    string er;
                    ec = exp_code_q.pop_front();
                    ef = exp_fail_q.pop_front();
                    er = exp_req_q.pop_front();
                    chk(int'($signed(dac_code)) == ec, er, "final dac code",
                        int'($signed(dac_code)), ec);
                    chk(fail == ef, "R8", "fail flag at done", fail, ef);
                    chk(!busy && !force_short, "R3", "short released at done",
                        force_short, 0);
                    chk(gain == user_gain, "R4", "user gain restored",
                        gain, user_gain);
                end
            end
        end
    end

    task automatic run_cal(input int raw_v, input int mode, input int code,
                           input bit fl, input string req, input bit inject,
                           input bit timed);
        int n;
        int held;
        raw   = raw_v;
        vmode = mode;
        push(code, fl, req);
        @(negedge clk);
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after request", busy, 1);
        chk(force_short == 1'b1, "R3", "short during pass", force_short, 1);
        chk(gain == 6'd60, "R4", "gain forced high", gain, 60);
        chk(fail == 1'b0, "R8", "fail cleared at new pass", fail, 0);
        n = 0;
        while (!done && n < 20000) begin
            cal_start = (inject && n == 100);
            @(negedge clk);
            n++;
        end
        cal_start = 1'b0;
        if (timed) chk(n == 81, "R6", "cycles to finish one trial", n, 81);
        held = int'($signed(dac_code));
        @(negedge clk);
        chk(!done, "R10", "done one cycle only", done, 0);
        repeat (30) @(negedge clk);
        chk(int'($signed(dac_code)) == held, "R10", "code held after pass",
            int'($signed(dac_code)), held);
        chk(fail == fl, "R8", "fail flag sticky", fail, fl);
        chk(!busy, "R9", "no second pass", busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        raw   = 0;
        vmode = 0;
        push(0, 1'b0, "R1");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R1", "busy right after reset", busy, 1);
        chk(force_short == 1'b1, "R3", "short right after reset", force_short, 1);
        chk(gain == 6'd60, "R4", "gain forced after reset", gain, 60);
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R1", "power-up pass completes", done, 1);
        repeat (5) @(negedge clk);

        run_cal(32,    0,   0,  1'b0, "R7", 1'b0, 1'b1);
        run_cal(33,    0,   32, 1'b0, "R7", 1'b0, 1'b0);
        run_cal(-33,   0,  -32, 1'b0, "R6", 1'b0, 1'b0);
        run_cal(200,   0,   96, 1'b0, "R6", 1'b0, 1'b0);
        user_gain = 6'd22;
        @(negedge clk);
        chk(gain == 6'd22, "R4", "idle gain follows user", gain, 22);
        run_cal(200,   1,   96, 1'b0, "R5", 1'b0, 1'b0);
        run_cal(33,    2,   32, 1'b0, "R5", 1'b0, 1'b0);
        run_cal(1500,  0,  127, 1'b1, "R8", 1'b0, 1'b0);
        run_cal(-1500, 0, -127, 1'b1, "R8", 1'b0, 1'b0);
        run_cal(200,   0,   96, 1'b0, "R9", 1'b1, 1'b0);

        chk(exp_code_q.size() == 0, "R10", "all passes completed",
            exp_code_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule